// File: doc/BRIEF.md
# Trigger-Driven Multi-Lane Execution Array

This block is a set of independent integer execution lanes, four by default, for a datapath whose operations start when data moves into a trigger port rather than when a shared opcode is decoded. Every lane receives two operand values, a destination register index and a one-hot set of operation triggers. In the cycle a single trigger is raised, the lane evaluates that operation. One clock later it presents the result with the destination index and a valid bit, ready for a write-back stage outside the block.

Each lane has its own operands, triggers and result buffer, so one lane may add while another shifts and a third compares, all in the same cycle. When a lane sees no trigger, its result buffer keeps the value it had. When a lane sees two or more triggers in the same cycle, it raises an error pulse and does not mark any result valid. The register file, memory access and instruction decode belong to neighbouring blocks.

Top module: `xlane_array`

## Requirements
- R1: Lane i takes its operands from bits [32i+31:32i] of `opa_i` and `opb_i`, its index from bits [5i+4:5i] of `tag_i`, and its triggers from bits [8i+7:8i] of `fire_i`. Inside a lane's trigger field, bit 0 is add, 1 is subtract, 2 is AND, 3 is OR, 4 is XOR, 5 is logical right shift, 6 is arithmetic right shift and 7 is signed set-less-than. The result of lane i appears at the same slices of `res_o` and `res_tag_o`, and at bit i of `res_vld_o` and `err_o`.
- R2: Add returns A+B and subtract returns A-B, both modulo 2^32.
- R3: The AND, OR and XOR triggers return the bitwise combination of A and B.
- R4: Logical right shift moves A right by the amount in bits [4:0] of B and fills with zeros. The upper bits of B are ignored.
- R5: Arithmetic right shift moves A right by bits [4:0] of B and fills with copies of bit 31 of A.
- R6: Set-less-than returns 1 when A is less than B as signed two's-complement values, and 0 otherwise, zero-extended to 32 bits.
- R7: When exactly one trigger of a lane is high at a rising edge, the lane's valid bit is 1 in the following cycle. In that cycle the result output holds the value of that operation on the sampled operands, and the index output holds the sampled index.
- R8: When no trigger of a lane is high at an edge, the lane's valid bit and error bit are 0 in the following cycle, and its result and index outputs keep their previous values.
- R9: When two or more triggers of a lane are high at an edge, the lane's error bit is 1 and its valid bit is 0 in the following cycle, and its result and index outputs keep their previous values.
- R10: A synchronous active-high reset sets every valid bit, error bit, result and index of every lane to zero.
- R11: Lanes are independent. The triggers and operands of one lane have no effect on the outputs of any other lane, even when the lanes run different operations in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opa_i | input | 128 | Operand A for each lane, 32 bits per lane |
| opb_i | input | 128 | Operand B for each lane, 32 bits per lane |
| tag_i | input | 20 | Destination register index for each lane, 5 bits per lane |
| fire_i | input | 32 | One-hot operation triggers, 8 per lane |
| res_o | output | 128 | Buffered result of each lane |
| res_tag_o | output | 20 | Buffered destination index of each lane |
| res_vld_o | output | 4 | Result valid pulse, one per lane |
| err_o | output | 4 | Trigger-conflict pulse, one per lane |

## Verification
Every lane holds its state in a result, index, valid and error register. A wrong value in any of these shows at the outputs in the cycle that follows the edge that wrote it. A result that is held wrongly shows up again in every idle or conflict cycle after it, until the next valid operation replaces it. The bench compares all four outputs of every lane in every cycle against a model. Because of this, a decode slip, a wrong shift fill or a lane cross-connection is reported within one cycle of the stimulus that exposes it.

// File: rtl/xlane_pkg.sv
package xlane_pkg;

   // number of trigger ports per lane; bit index equals op code
   localparam int unsigned NOPS = 8;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_IOR = 3'd3,
      OP_XOR = 3'd4,
      OP_SRL = 3'd5,
      OP_SRA = 3'd6,
      OP_SLT = 3'd7
   } op_e;

endpackage

// File: rtl/xlane_shift.sv
module xlane_shift #(
   parameter int unsigned W    = 32,
   parameter int unsigned IMPL = 1,   // 0: shift operator, 1: explicit log stages
   localparam int unsigned SHW = $clog2(W)
) (
   input  logic [W-1:0]   val_i,
   input  logic [SHW-1:0] amt_i,
   input  logic           arith_i,
   output logic [W-1:0]   val_o
);

   if ((1 << SHW) != W) begin : g_bad_width
      $error("xlane_shift: W must be a power of two");
   end

   if (IMPL == 0) begin : g_op
      always_comb begin
         if (arith_i) val_o = W'($signed(val_i) >>> amt_i);
         else         val_o = val_i >> amt_i;
      end
   end else begin : g_stages
      logic          fill;
      logic [W-1:0]  stg [SHW+1];

      assign fill   = arith_i & val_i[W-1];
      assign stg[0] = val_i;

      for (genvar k = 0; k < SHW; k++) begin : g_st
         localparam int unsigned D = 1 << k;
         assign stg[k+1] = amt_i[k] ? {{D{fill}}, stg[k][W-1:D]} : stg[k];
      end

      assign val_o = stg[SHW];
   end

endmodule

// File: rtl/xlane_trig_dec.sv
module xlane_trig_dec
   import xlane_pkg::*;
(
   input  logic [NOPS-1:0] fire_i,
   output logic            any_o,
   output logic            single_o,
   output op_e             op_o
);

   logic [NOPS-1:0] low_cleared;

   assign low_cleared = fire_i & (fire_i - NOPS'(1));
   assign any_o       = |fire_i;
   assign single_o    = any_o & ~(|low_cleared);

   always_comb begin
      op_o = OP_ADD;
      for (int i = 0; i < NOPS; i++) begin
         if (fire_i[i]) op_o = op_e'(3'(i));
      end
   end

endmodule

// File: rtl/xlane_alu.sv
module xlane_alu
   import xlane_pkg::*;
#(
   parameter int unsigned W          = 32,
   parameter int unsigned SHIFT_IMPL = 1,
   localparam int unsigned SHW       = $clog2(W)
) (
   input  op_e          op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] y_o
);

   logic [W-1:0] sh_y;
   logic         lt;

   xlane_shift #(.W(W), .IMPL(SHIFT_IMPL)) u_sh (
      .val_i   (a_i),
      .amt_i   (b_i[SHW-1:0]),
      .arith_i (op_i == OP_SRA),
      .val_o   (sh_y)
   );

   assign lt = $signed(a_i) < $signed(b_i);

   always_comb begin
      unique case (op_i)
         OP_ADD:  y_o = a_i + b_i;
         OP_SUB:  y_o = a_i - b_i;
         OP_AND:  y_o = a_i & b_i;
         OP_IOR:  y_o = a_i | b_i;
         OP_XOR:  y_o = a_i ^ b_i;
         OP_SRL,
         OP_SRA:  y_o = sh_y;
         OP_SLT:  y_o = {{(W-1){1'b0}}, lt};
         default: y_o = '0;
      endcase
   end

endmodule

// File: rtl/xlane_lane.sv
module xlane_lane
   import xlane_pkg::*;
#(
   parameter int unsigned W          = 32,
   parameter int unsigned TAGW       = 5,
   parameter int unsigned SHIFT_IMPL = 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [W-1:0]    a_i,
   input  logic [W-1:0]    b_i,
   input  logic [TAGW-1:0] tag_i,
   input  logic [NOPS-1:0] fire_i,
   output logic [W-1:0]    res_o,
   output logic [TAGW-1:0] tag_o,
   output logic            vld_o,
   output logic            err_o
);

   logic         any_f, single_f;
   op_e          op;
   logic [W-1:0] alu_y;

   logic [W-1:0]    res_q;
   logic [TAGW-1:0] tag_q;
   logic            vld_q, err_q;

   xlane_trig_dec u_dec (
      .fire_i   (fire_i),
      .any_o    (any_f),
      .single_o (single_f),
      .op_o     (op)
   );

   xlane_alu #(.W(W), .SHIFT_IMPL(SHIFT_IMPL)) u_alu (
      .op_i (op),
      .a_i  (a_i),
      .b_i  (b_i),
      .y_o  (alu_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q <= '0;
         tag_q <= '0;
         vld_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         vld_q <= single_f;
         err_q <= any_f & ~single_f;
         if (single_f) begin
            res_q <= alu_y;
            tag_q <= tag_i;
         end
      end
   end

   assign res_o = res_q;
   assign tag_o = tag_q;
   assign vld_o = vld_q;
   assign err_o = err_q;

   // R7
   single_fire_vld_chk: assert property (@(posedge clk) disable iff (rst)
      ($countones(fire_i) == 1) |=> (vld_q && !err_q));

   // R9
   multi_fire_err_chk: assert property (@(posedge clk) disable iff (rst)
      ($countones(fire_i) > 1) |=> (err_q && !vld_q && $stable(res_q) && $stable(tag_q)));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (fire_i == '0) |=> (!vld_q && !err_q && $stable(res_q) && $stable(tag_q)));

   // R6
   slt_range_chk: assert property (@(posedge clk) disable iff (rst)
      (fire_i == NOPS'(1) << OP_SLT) |=> (res_q[W-1:1] == '0));

   // R9
   vld_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(vld_q && err_q));

   // R10
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!vld_q && !err_q && res_q == '0 && tag_q == '0));

endmodule

// File: rtl/xlane_array.sv
module xlane_array
   import xlane_pkg::*;
#(
   parameter int unsigned LANES      = 4,
   parameter int unsigned W          = 32,
   parameter int unsigned TAGW       = 5,
   parameter int unsigned SHIFT_IMPL = 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [LANES*W-1:0]     opa_i,
   input  logic [LANES*W-1:0]     opb_i,
   input  logic [LANES*TAGW-1:0]  tag_i,
   input  logic [LANES*NOPS-1:0]  fire_i,
   output logic [LANES*W-1:0]     res_o,
   output logic [LANES*TAGW-1:0]  res_tag_o,
   output logic [LANES-1:0]       res_vld_o,
   output logic [LANES-1:0]       err_o
);

   if (LANES < 1) begin : g_bad_lanes
      $error("xlane_array: LANES must be at least 1");
   end
   if (W < 2) begin : g_bad_w
      $error("xlane_array: W must be at least 2");
   end
   if (TAGW < 1) begin : g_bad_tag
      $error("xlane_array: TAGW must be at least 1");
   end
   if (SHIFT_IMPL > 1) begin : g_bad_impl
      $error("xlane_array: SHIFT_IMPL must be 0 or 1");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      xlane_lane #(.W(W), .TAGW(TAGW), .SHIFT_IMPL(SHIFT_IMPL)) u_lane (
         .clk    (clk),
         .rst    (rst),
         .a_i    (opa_i[i*W +: W]),
         .b_i    (opb_i[i*W +: W]),
         .tag_i  (tag_i[i*TAGW +: TAGW]),
         .fire_i (fire_i[i*NOPS +: NOPS]),
         .res_o  (res_o[i*W +: W]),
         .tag_o  (res_tag_o[i*TAGW +: TAGW]),
         .vld_o  (res_vld_o[i]),
         .err_o  (err_o[i])
      );
   end

endmodule

// File: tb/sim_xlane_array.sv
`timescale 1ns/1ps
module sim_xlane_array;

   localparam int L = 4;
   localparam int W = 32;
   localparam int T = 5;
   localparam int N = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [L*W-1:0] opa, opb, res;
   logic [L*T-1:0] tg, rtg;
   logic [L*N-1:0] fire;
   logic [L-1:0]   vld, err;

   logic [W-1:0] a   [L];
   logic [W-1:0] b   [L];
   logic [T-1:0] t   [L];
   logic [N-1:0] fr  [L];

   logic [W-1:0] e_res [L];
   logic [T-1:0] e_tag [L];
   logic         e_vld [L];
   logic         e_err [L];

   int checks   = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < L; i++) begin
         opa[i*W +: W]  = a[i];
         opb[i*W +: W]  = b[i];
         tg[i*T +: T]   = t[i];
         fire[i*N +: N] = fr[i];
      end
   end

   xlane_array u0 (
      .clk(clk), .rst(rst), .opa_i(opa), .opb_i(opb), .tag_i(tg), .fire_i(fire),
      .res_o(res), .res_tag_o(rtg), .res_vld_o(vld), .err_o(err)
   );

   function automatic logic [W-1:0] ref_op(int op, logic [W-1:0] x, logic [W-1:0] y);
      int sh = int'(y[4:0]);
      case (op)
         0: return x + y;
         1: return x - y;
         2: return x & y;
         3: return x | y;
         4: return x ^ y;
         5: return x >> sh;
         6: return W'($signed(x) >>> sh);
         default: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      endcase
   endfunction

   function automatic int op_idx(logic [N-1:0] f);
      for (int k = 0; k < N; k++) if (f[k]) return k;
      return 0;
   endfunction

   function automatic string req_of(logic [N-1:0] f);
      int n = $countones(f);
      if (n == 0) return "R8";
      if (n > 1)  return "R9";
      case (op_idx(f))
         0, 1:    return "R2/R7";
         2, 3, 4: return "R3/R7";
         5:       return "R4/R7";
         6:       return "R5/R7";
         default: return "R6/R7";
      endcase
   endfunction

   task automatic step(input string ovr);
      string rq [L];
      for (int i = 0; i < L; i++) begin
         rq[i] = (ovr != "") ? ovr : req_of(fr[i]);
         if (rst) begin
            e_res[i] = '0; e_tag[i] = '0; e_vld[i] = 1'b0; e_err[i] = 1'b0;
         end else if ($countones(fr[i]) == 0) begin
            e_vld[i] = 1'b0; e_err[i] = 1'b0;
         end else if ($countones(fr[i]) == 1) begin
            e_res[i] = ref_op(op_idx(fr[i]), a[i], b[i]);
            e_tag[i] = t[i]; e_vld[i] = 1'b1; e_err[i] = 1'b0;
         end else begin
            e_vld[i] = 1'b0; e_err[i] = 1'b1;
         end
      end
      @(posedge clk);
      #1;
      for (int i = 0; i < L; i++) begin
         checks++;
         if (res[i*W +: W] !== e_res[i] || rtg[i*T +: T] !== e_tag[i] ||
             vld[i] !== e_vld[i] || err[i] !== e_err[i]) begin
            failures++;
            $display("FAIL %s lane %0d: got res=%h tag=%h vld=%b err=%b exp res=%h tag=%h vld=%b err=%b",
                     rq[i], i, res[i*W +: W], rtg[i*T +: T], vld[i], err[i],
                     e_res[i], e_tag[i], e_vld[i], e_err[i]);
         end
      end
   endtask

   task automatic idle_all();
      for (int i = 0; i < L; i++) begin
         a[i] = '0; b[i] = '0; t[i] = '0; fr[i] = '0;
      end
   endtask

   task automatic set_lane(int i, int op, logic [W-1:0] x, logic [W-1:0] y, logic [T-1:0] d);
      a[i] = x; b[i] = y; t[i] = d; fr[i] = N'(1) << op;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd7781));
      idle_all();
      rst = 1'b1;
      // R10: reset clears every lane even with triggers raised
      for (int i = 0; i < L; i++) set_lane(i, i, 32'h55, 32'h3, 5'(i + 1));
      step("R10");
      step("R10");
      rst = 1'b0;
      idle_all();
      step("R8");

      // R1: distinct op, operands and index per lane slice
      set_lane(0, 0, 32'hFFFF_FFFF, 32'd2, 5'd1);
      set_lane(1, 1, 32'd0, 32'd1, 5'd2);
      set_lane(2, 2, 32'hF0F0_1234, 32'h0FF0_FFFF, 5'd3);
      set_lane(3, 4, 32'hAAAA_AAAA, 32'h5555_5555, 5'd31);
      step("R1");

      // R4: shift amount taken from low 5 bits only (37 -> 5)
      set_lane(0, 5, 32'h8000_0000, 32'd37, 5'd4);
      // R5: sign fill, maximum shift
      set_lane(1, 6, 32'h8000_0000, 32'd31, 5'd5);
      // R6: signed compare corner
      set_lane(2, 7, 32'hFFFF_FFFF, 32'd1, 5'd6);
      set_lane(3, 7, 32'd1, 32'hFFFF_FFFF, 5'd7);
      step("");

      // R11: lanes differ, one lane conflicting, one idle
      set_lane(0, 3, 32'h0000_00F0, 32'h0000_000F, 5'd8);
      set_lane(1, 6, 32'h7FFF_FFFF, 32'd4, 5'd9);
      fr[2] = 8'b1000_0001; a[2] = 32'd9; b[2] = 32'd9; t[2] = 5'd10;
      fr[3] = '0;
      step("R11");

      // R9: all lanes conflict, outputs held
      for (int i = 0; i < L; i++) begin
         fr[i] = 8'hFF; a[i] = $urandom; b[i] = $urandom; t[i] = 5'($urandom);
      end
      step("R9");
      // R8: idle after conflict, outputs held
      idle_all();
      step("R8");

      for (int c = 0; c < 3000; c++) begin
         for (int i = 0; i < L; i++) begin
            int r = int'($urandom_range(0, 99));
            a[i] = (r % 7 == 0) ? 32'h8000_0000 : $urandom;
            b[i] = (r % 5 == 0) ? 32'hFFFF_FFFF : $urandom;
            t[i] = 5'($urandom);
            if (r < 15)      fr[i] = '0;
            else if (r < 25) fr[i] = N'((1 << $urandom_range(0, 7)) | (1 << $urandom_range(0, 7)) | 1);
            else             fr[i] = N'(1) << $urandom_range(0, 7);
            if (r < 25 && $countones(fr[i]) == 1) fr[i] = 8'h03;
         end
         if (c == 1500) rst = 1'b1;
         step(rst ? "R10" : "");
         rst = 1'b0;
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule